// File: doc/BRIEF.md
# Pipelined Registered ROM with Shared Enable/Initialize Control

This block is a synthesizable model of a read-only memory of 8192 words by 8 bits with an output pipeline register. On every rising clock edge the word at the current address is captured into the register, so the address may move on to the next location while the previous word stays steady at the outputs. The memory contents are computed from the address by a fixed formula rather than held in a table, which keeps elaboration cheap while still giving every location a distinct, predictable value.

A single control input, `pin_ctl`, takes one of three roles, chosen by the architecture byte `arch_mode`. It can act as an immediate output enable, as an output enable sampled on the clock edge, or as an immediate load of a programmed initialize word into the register. In the initialize role the outputs are always driven, and a low level on the pin also stops the clock from updating the register. The initialize word is a parameter: all zeros gives a register clear and all ones gives a preset. The tri-state output drivers are modelled by the flag `dout_en`.

Top module: `piped_rom`

## Requirements
- R1: Each rising edge with `rst` low and no active initialize captures word(a) for the address a present at that edge, where word(a) = ((a mod 256) XOR (a div 256)) + 0x5A, taken mod 256. The result appears on `dout` after that edge.
- R2: A change of `addr` between two rising edges leaves `dout` unchanged until the next rising edge.
- R3: `arch_mode` 0x01 selects the clocked-enable role and 0x02 selects the initialize role. Every other value, 0x00 among them, selects the immediate-enable role.
- R4: In the immediate-enable role, `dout_en` equals the inverse of `pin_ctl` without waiting for a clock edge. The register keeps loading while the outputs are disabled.
- R5: In the clocked-enable role, `pin_ctl` is sampled on the rising edge. `dout_en` becomes the inverse of the sampled level after that edge, and a level change between edges has no effect on `dout_en`.
- R6: In the initialize role, `dout_en` is always 1. Driving `pin_ctl` low puts INIT_WORD on `dout` at once, without a clock edge.
- R7: While the initialize role is active with `pin_ctl` low, rising edges do not change `dout`. After `pin_ctl` returns high, `dout` keeps INIT_WORD until the next rising edge, which captures the addressed word again.
- R8: An INIT_WORD of 0x00 makes initialize clear `dout` to all zeros, and an INIT_WORD of 0xFF makes it preset `dout` to all ones.
- R9: A rising edge with `rst` high and no active initialize sets the register to zero and sets the clocked-enable state to enabled. This holds even if `pin_ctl` is high in the clocked-enable role.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Word address |
| pin_ctl | input | 1 | Shared enable / initialize control, low active |
| arch_mode | input | 8 | Architecture byte that selects the role of `pin_ctl` |
| dout | output | 8 | Output pipeline register contents |
| dout_en | output | 1 | Output driver enable, 1 = driven, 0 = high impedance |

## Verification
The initialize load and the normal clocked capture can both claim the register in the same cycle. This happens when `pin_ctl` is held low in the initialize role across one or more rising edges, and during that time the address is moved to a location whose word differs from the initialize word. The bench judges the result by checking that `dout` still shows the initialize word after each such edge. It then checks again after the pin is released but before the next edge. Finally it checks that the first edge after release brings back the addressed word. The bench also changes the address between edges and drives the enable pin between edges in the clocked role, to confirm that neither input reaches the outputs before the clock edge.

// File: rtl/piped_rom_pkg.sv
package piped_rom_pkg;

    localparam int ROLE_CODE_W = 8;
    localparam logic [ROLE_CODE_W-1:0] ROLE_CODE_SYNC = 8'h01;
    localparam logic [ROLE_CODE_W-1:0] ROLE_CODE_INIT = 8'h02;

    typedef enum logic [1:0] {
        PIN_ASYNC_OE = 2'd0,
        PIN_SYNC_OE  = 2'd1,
        PIN_INIT     = 2'd2
    } pin_role_e;

    typedef struct packed {
        pin_role_e role;
        logic      load_init;
        logic      pin_high;
    } ctl_view_t;

    function automatic pin_role_e decode_role(input logic [ROLE_CODE_W-1:0] code);
        case (code)
            ROLE_CODE_SYNC: return PIN_SYNC_OE;
            ROLE_CODE_INIT: return PIN_INIT;
            default:        return PIN_ASYNC_OE;
        endcase
    endfunction

    function automatic ctl_view_t build_view(input logic [ROLE_CODE_W-1:0] code,
                                             input logic pin);
        ctl_view_t v;
        v.role      = decode_role(code);
        v.pin_high  = pin;
        v.load_init = (v.role == PIN_INIT) && !pin;
        return v;
    endfunction

endpackage

// File: rtl/piped_rom_core.sv
module piped_rom_core #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SEED = 8'h5A
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    localparam int FOLD_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

    logic [FOLD_W-1:0] addr_ext;
    logic [FOLD_W-1:0] upper;

    assign addr_ext = FOLD_W'(addr);

    generate
        if (ADDR_W > DATA_W) begin : g_fold
            assign upper = addr_ext >> DATA_W;
        end else begin : g_flat
            assign upper = '0;
        end
    endgenerate

    assign word = (addr_ext[DATA_W-1:0] ^ upper[DATA_W-1:0]) + SEED;

endmodule

// File: rtl/piped_rom_outreg.sv
module piped_rom_outreg #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_init,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // The initialize load wins over the clock and over reset.
    always_ff @(posedge clk or posedge load_init) begin
        if (load_init) begin
            q <= INIT_WORD;
        end else if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/piped_rom_oectl.sv
module piped_rom_oectl
    import piped_rom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_view_t view,
    output logic      drive_en
);
    logic sync_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_en_q <= 1'b1;
        end else if (view.role == PIN_SYNC_OE) begin
            sync_en_q <= !view.pin_high;
        end else begin
            sync_en_q <= 1'b1;
        end
    end

    always_comb begin
        case (view.role)
            PIN_SYNC_OE: drive_en = sync_en_q;
            PIN_INIT:    drive_en = 1'b1;
            default:     drive_en = !view.pin_high;
        endcase
    end

endmodule

// File: rtl/piped_rom.sv
module piped_rom
    import piped_rom_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = '0,
    parameter logic [DATA_W-1:0] SEED = 8'h5A
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   pin_ctl,
    input  logic [ROLE_CODE_W-1:0] arch_mode,
    output logic [DATA_W-1:0]      dout,
    output logic                   dout_en
);
    ctl_view_t         view;
    logic [DATA_W-1:0] array_word;

    assign view = build_view(arch_mode, pin_ctl);

    piped_rom_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEED   (SEED)
    ) u_core (
        .addr (addr),
        .word (array_word)
    );

    piped_rom_outreg #(
        .DATA_W    (DATA_W),
        .INIT_WORD (INIT_WORD)
    ) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .load_init (view.load_init),
        .d         (array_word),
        .q         (dout)
    );

    piped_rom_oectl u_oectl (
        .clk      (clk),
        .rst      (rst),
        .view     (view),
        .drive_en (dout_en)
    );

endmodule

// File: rtl/piped_rom_chk.sv
module piped_rom_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = '0,
    parameter logic [DATA_W-1:0] SEED = 8'h5A
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              pin_ctl,
    input logic [7:0]        arch_mode,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    logic              in_init;
    logic              holding;
    logic [ADDR_W-1:0] hi_addr;
    logic [DATA_W-1:0] exp_now;

    assign in_init = (arch_mode == 8'h02);
    assign holding = in_init && (pin_ctl == 1'b0);
    assign hi_addr = addr >> DATA_W;
    assign exp_now = DATA_W'(addr) ^ DATA_W'(hi_addr);

    // R1
    rom_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!holding) ##1 (!holding) |-> dout == $past(exp_now + SEED));

    // R4
    async_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (arch_mode != 8'h01 && !in_init) |-> dout_en == !pin_ctl);

    // R5
    sync_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (arch_mode == 8'h01) ##1 (arch_mode == 8'h01) |-> dout_en == !$past(pin_ctl));

    // R6
    init_oe_chk: assert property (@(posedge clk) disable iff (rst)
        in_init |-> dout_en);

    // R6
    init_load_chk: assert property (@(posedge clk) disable iff (rst)
        holding |-> dout == INIT_WORD);

    // R7
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        holding ##1 holding |-> $stable(dout));

endmodule

bind piped_rom piped_rom_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .INIT_WORD (INIT_WORD),
    .SEED      (SEED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .pin_ctl   (pin_ctl),
    .arch_mode (arch_mode),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/sim_piped_rom.sv
`timescale 1ns/1ps
module sim_piped_rom;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] addr;
    logic        pin_ctl;
    logic [7:0]  arch_mode;
    logic [7:0]  dout0, dout1;
    logic        en0, en1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    piped_rom u0 (
        .clk(clk), .rst(rst), .addr(addr), .pin_ctl(pin_ctl),
        .arch_mode(arch_mode), .dout(dout0), .dout_en(en0)
    );

    piped_rom #(.INIT_WORD(8'hFF)) u1 (
        .clk(clk), .rst(rst), .addr(addr), .pin_ctl(pin_ctl),
        .arch_mode(arch_mode), .dout(dout1), .dout_en(en1)
    );

    function automatic logic [7:0] word_of(input logic [12:0] a);
        return (a[7:0] ^ {3'b000, a[12:8]}) + 8'h5A;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; addr = '0; pin_ctl = 1'b0; arch_mode = 8'h00;
        tick(); tick();
        // R9 reset state
        chk("R9 reset dout", dout0, 8'h00);
        chk("R9 reset en", {7'd0, en0}, 8'h01);
        rst = 1'b0;

        // R1 exhaustive sweep of the address space
        for (int a = 0; a < 8192; a++) begin
            addr = 13'(a);
            tick();
            chk("R1 capture u0", dout0, word_of(13'(a)));
            if (a % 512 == 0) chk("R1 capture u1", dout1, word_of(13'(a)));
        end

        // R2 address moves between edges
        addr = 13'h0123; tick();
        addr = 13'h1456; #1;
        chk("R2 hold", dout0, word_of(13'h0123));
        tick();
        chk("R2 next edge", dout0, word_of(13'h1456));

        // R4 immediate enable
        pin_ctl = 1'b1; #1;
        chk("R4 off now", {7'd0, en0}, 8'h00);
        addr = 13'h0077; tick();
        chk("R4 still off", {7'd0, en0}, 8'h00);
        chk("R4 loads while off", dout0, word_of(13'h0077));
        pin_ctl = 1'b0; #1;
        chk("R4 on now", {7'd0, en0}, 8'h01);

        // R3 undefined code acts as immediate enable
        arch_mode = 8'h07; pin_ctl = 1'b1; #1;
        chk("R3 code 07 off", {7'd0, en0}, 8'h00);
        pin_ctl = 1'b0; #1;
        chk("R3 code 07 on", {7'd0, en0}, 8'h01);

        // R5 clocked enable
        arch_mode = 8'h01; tick();
        chk("R5 enabled", {7'd0, en0}, 8'h01);
        pin_ctl = 1'b1; #1;
        chk("R5 no early off", {7'd0, en0}, 8'h01);
        tick();
        chk("R5 off at edge", {7'd0, en0}, 8'h00);
        pin_ctl = 1'b0; #1;
        chk("R5 no early on", {7'd0, en0}, 8'h00);
        tick();
        chk("R5 on at edge", {7'd0, en0}, 8'h01);

        // R9 reset restores enabled state in clocked role
        pin_ctl = 1'b1; tick();
        chk("R9 pre off", {7'd0, en0}, 8'h00);
        rst = 1'b1; tick();
        chk("R9 en after reset", {7'd0, en0}, 8'h01);
        chk("R9 dout after reset", dout0, 8'h00);
        rst = 1'b0; pin_ctl = 1'b0; tick();

        // R6 / R8 initialize role
        arch_mode = 8'h02; pin_ctl = 1'b1; addr = 13'h00AB; tick();
        chk("R6 en with pin high", {7'd0, en0}, 8'h01);
        chk("R6 normal capture", dout0, word_of(13'h00AB));
        pin_ctl = 1'b0; #1;
        chk("R8 clear", dout0, 8'h00);
        chk("R8 preset", dout1, 8'hFF);
        chk("R6 en while init", {7'd0, en1}, 8'h01);

        // R7 edges ignored during initialize
        addr = 13'h1FFF; tick();
        chk("R7 u0 held", dout0, 8'h00);
        chk("R7 u1 held", dout1, 8'hFF);
        tick();
        chk("R7 u1 held again", dout1, 8'hFF);
        pin_ctl = 1'b1; #1;
        chk("R7 after release", dout1, 8'hFF);
        tick();
        chk("R7 resume u0", dout0, word_of(13'h1FFF));
        chk("R7 resume u1", dout1, 8'h3A);

        finish_run();
    end

endmodule